// File: doc/BRIEF.md
# Two-Phase Stage Decision Aligner

A seven-stage pipelined converter resolves a 2-bit coarse decision pair (A, B) in every stage, but not all at once. Odd-numbered stages latch on the first phase of a two-phase clock and even-numbered stages on the second. The pairs belonging to one analog sample therefore arrive spread over three and a half clock periods, one half-period apart. This block collects those pairs and delays each one by a stage-dependent number of half-cycles, so that all fourteen bits of a sample reach the digital correction adder together.

Both phases are modelled on a single clock. The rising edge stands for the first phase and the falling edge for the second. Each stage owns a chain of 2-bit flops whose clock edges alternate. The chain starts on that stage's own capture edge and ends on a falling edge that all stages share. Stage 1 has the longest chain and stage 7 the shortest. A small fill sequencer raises a valid flag when the first fully post-reset sample reaches the output. The states of that sequencer are CLEAR, FILL and LIVE:

- CLEAR is held while reset is high.
- CLEAR moves to FILL on the first rising edge with reset low.
- FILL counts rising edges and moves to LIVE on the fourth one.
- LIVE is kept until reset.

The valid flag is registered on the falling edge from the LIVE state.

Top module: `adc_decision_align`

## Requirements
- R1: A falling edge that samples `rst` high leaves `aligned_word` at zero and `aligned_valid` low, and both stay that way while `rst` remains high.
- R2: In both `dec_in` and `aligned_word`, stage k (1 to 7) occupies bits [15-2k:14-2k], with its A bit in the higher position. Stage 1 is therefore at [13:12] and stage 7 at [1:0].
- R3: Odd-numbered stages (1, 3, 5, 7) are sampled on the rising edge of `clk` and even-numbered stages (2, 4, 6) on the falling edge. Stage k of a sample is captured (k-1) half-cycles after that sample's stage-1 capture.
- R4: Take a sample whose stage-1 pair is captured at rising edge m. All 14 bits of that sample appear together on `aligned_word` at the falling edge of the same cycle as rising edge m+3, which is 3.5 cycles later, and remain until the next falling edge.
- R5: `aligned_word` changes only at falling edges of `clk` and holds its value across rising edges.
- R6: After reset is released, `aligned_valid` stays low until the falling edge that follows the fourth rising edge sampling `rst` low, and rises at that falling edge. The word it qualifies is the sample whose stage-1 capture was the first rising edge with `rst` low.
- R7: Once high, `aligned_valid` stays high at every later falling edge until reset is asserted.
- R8: Asserting reset in the middle of a stream clears the output and the flag. The fill sequence then restarts after release with the same timing as R6.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock: rising edge is the first phase, falling edge the second |
| rst | input | 1 | Synchronous active-high reset, sampled on both edges |
| dec_in | input | 14 | Seven stage decision pairs, stage 1 in the top two bits |
| aligned_word | output | 14 | Time-aligned decision pairs of one sample, same layout as `dec_in` |
| aligned_valid | output | 1 | High once the output carries a sample captured entirely after reset |

## Verification
A flop on the wrong edge, or one flop too many or too few in a stage chain, shows at the very next valid output. The pair for that stage is taken from the neighbouring sample while the other stages stay correct, so a scoreboard of distinct samples points to the offending field within four cycles of reset release. A fault in the fill sequencer shows as a valid edge one cycle early or late. The first qualified word is then a partially cleared sample, or a correct sample is dropped. A flag that falls while streaming shows up on the following falling edge.

// File: rtl/adc_align_pkg.sv
`timescale 1ns/1ps
package adc_align_pkg;

    // Fill sequencer states
    typedef enum logic [1:0] {
        ST_CLEAR = 2'd0,
        ST_FILL  = 2'd1,
        ST_LIVE  = 2'd2
    } fill_state_t;

endpackage

// File: rtl/dec_delay_line.sv
`timescale 1ns/1ps
// Chain of DEPTH registers of width W whose clock edges alternate.
// The first register uses the rising edge when FIRST_RISE is set.
module dec_delay_line #(
    parameter int W          = 2,
    parameter int DEPTH      = 2,
    parameter bit FIRST_RISE = 1'b1
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] din,
    output logic [W-1:0] dout
);

    logic [W-1:0] link [DEPTH+1];

    assign link[0] = din;

    for (genvar j = 0; j < DEPTH; j++) begin : g_tap
        localparam bit RISE = ((j % 2) == 0) ? FIRST_RISE : !FIRST_RISE;
        logic [W-1:0] q;

        if (RISE) begin : g_rise
            always_ff @(posedge clk) begin
                if (rst) q <= '0;
                else     q <= link[j];
            end
        end else begin : g_fall
            always_ff @(negedge clk) begin
                if (rst) q <= '0;
                else     q <= link[j];
            end
        end

        assign link[j+1] = q;
    end

    assign dout = link[DEPTH];

endmodule

// File: rtl/fill_tracker.sv
`timescale 1ns/1ps
// Counts rising edges after reset until the alignment pipe holds a
// complete post-reset sample; the flag is registered on the falling edge.
module fill_tracker
    import adc_align_pkg::*;
#(
    parameter int FILL_EDGES = 4
) (
    input  logic clk,
    input  logic rst,
    output logic valid_q
);

    localparam int CW = $clog2(FILL_EDGES + 1);
    localparam logic [CW-1:0] LAST = CW'(FILL_EDGES - 1);

    fill_state_t   state_q, state_n;
    logic [CW-1:0] cnt_q, cnt_n;
    logic          live;

    // State register
    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_CLEAR;
            cnt_q   <= '0;
        end else begin
            state_q <= state_n;
            cnt_q   <= cnt_n;
        end
    end

    // Transitions
    always_comb begin
        state_n = state_q;
        cnt_n   = cnt_q;
        unique case (state_q)
            ST_CLEAR: begin
                state_n = ST_FILL;
                cnt_n   = CW'(1);
            end
            ST_FILL: begin
                if (cnt_q == LAST) state_n = ST_LIVE;
                else               cnt_n   = cnt_q + CW'(1);
            end
            ST_LIVE:  state_n = ST_LIVE;
            default:  state_n = ST_CLEAR;
        endcase
    end

    // Outputs
    always_comb begin
        unique case (state_q)
            ST_LIVE: live = 1'b1;
            default: live = 1'b0;
        endcase
    end

    always_ff @(negedge clk) begin
        if (rst) valid_q <= 1'b0;
        else     valid_q <= live;
    end

endmodule

// File: rtl/adc_decision_align.sv
`timescale 1ns/1ps
// Aligns staggered stage decision pairs so one sample's bits emerge together.
// N_STAGES must be odd so that the last stage captures on the rising edge.
module adc_decision_align #(
    parameter int N_STAGES = 7,
    parameter int PAIR_W   = 2
) (
    input  logic                         clk,
    input  logic                         rst,
    input  logic [N_STAGES*PAIR_W-1:0]   dec_in,
    output logic [N_STAGES*PAIR_W-1:0]   aligned_word,
    output logic                         aligned_valid
);

    localparam int WORD_W     = N_STAGES * PAIR_W;
    localparam int OUT_HALF   = N_STAGES;          // half-cycle of shared output edge
    localparam int FILL_EDGES = (N_STAGES + 1) / 2;

    for (genvar i = 0; i < N_STAGES; i++) begin : g_stage
        localparam int HI    = WORD_W - 1 - i * PAIR_W;
        localparam int DEPTH = OUT_HALF - i + 1;

        dec_delay_line #(
            .W          (PAIR_W),
            .DEPTH      (DEPTH),
            .FIRST_RISE ((i % 2) == 0)
        ) u_line (
            .clk  (clk),
            .rst  (rst),
            .din  (dec_in[HI -: PAIR_W]),
            .dout (aligned_word[HI -: PAIR_W])
        );
    end

    fill_tracker #(
        .FILL_EDGES (FILL_EDGES)
    ) u_fill (
        .clk     (clk),
        .rst     (rst),
        .valid_q (aligned_valid)
    );

endmodule

// File: rtl/adc_decision_align_chk.sv
`timescale 1ns/1ps
module adc_decision_align_chk #(
    parameter int N_STAGES = 7,
    parameter int PAIR_W   = 2
) (
    input logic                       clk,
    input logic                       rst,
    input logic [N_STAGES*PAIR_W-1:0] dec_in,
    input logic [N_STAGES*PAIR_W-1:0] aligned_word,
    input logic                       aligned_valid
);

    localparam int WORD_W = N_STAGES * PAIR_W;

    logic [PAIR_W-1:0] last_rise;   // last stage pair seen at rising edge
    logic [WORD_W-1:0] rise_snap;   // output as seen at rising edge

    always_ff @(posedge clk) begin
        if (rst) begin
            last_rise <= '0;
            rise_snap <= '0;
        end else begin
            last_rise <= dec_in[PAIR_W-1:0];
            rise_snap <= aligned_word;
        end
    end

    // R1: reset seen on a falling edge clears word and flag
    assert_reset_clears_R1: assert property (@(negedge clk)
        rst |=> (aligned_word == '0 && !aligned_valid));

    // R3: next-to-last stage captured on the falling edge, one falling edge before output
    assert_fall_stage_R3: assert property (@(negedge clk) disable iff (rst)
        aligned_valid |-> aligned_word[2*PAIR_W-1:PAIR_W] == $past(dec_in[2*PAIR_W-1:PAIR_W], 2));

    // R4: last stage captured on the rising edge half a cycle before output
    assert_last_stage_R4: assert property (@(negedge clk) disable iff (rst)
        aligned_valid |-> aligned_word[PAIR_W-1:0] == $past(last_rise));

    // R5: no change between a rising edge and the next falling edge
    assert_word_holds_R5: assert property (@(negedge clk) disable iff (rst)
        aligned_valid |-> aligned_word == rise_snap);

    // R7: flag never drops while out of reset
    assert_valid_sticky_R7: assert property (@(negedge clk) disable iff (rst)
        aligned_valid |=> aligned_valid);

endmodule

bind adc_decision_align adc_decision_align_chk #(
    .N_STAGES (N_STAGES),
    .PAIR_W   (PAIR_W)
) u_chk (
    .clk           (clk),
    .rst           (rst),
    .dec_in        (dec_in),
    .aligned_word  (aligned_word),
    .aligned_valid (aligned_valid)
);

// File: tb/adc_decision_align_tb.sv
`timescale 1ns/1ps
module adc_decision_align_tb_top;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [13:0] dec_in = 14'h2AAA;
    logic [13:0] aligned_word;
    logic        aligned_valid;

    int n_checks = 0;
    int n_fail   = 0;

    logic [13:0] smp [64];
    int          smp_n = 0;
    logic [13:0] sb_q [$];

    adc_decision_align dut_i (
        .clk           (clk),
        .rst           (rst),
        .dec_in        (dec_in),
        .aligned_word  (aligned_word),
        .aligned_valid (aligned_valid)
    );

    always #10 clk = ~clk;   // 50 MHz

    task automatic check(input bit ok, input string tag, input string what,
                         input logic [13:0] act, input logic [13:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    // Drive, for half-cycle r after release, the stages whose capture edge is r.
    task automatic set_fields(input int r);
        for (int i = 0; i < 7; i++) begin
            if (r >= i && ((r - i) % 2) == 0) begin
                int n = (r - i) / 2;
                dec_in[13-2*i -: 2] = (n < smp_n) ? smp[n][13-2*i -: 2] : 2'b00;
            end
        end
    endtask

    task automatic reset_state_check(input string tag);
        @(negedge clk); #3;
        check(aligned_word == 14'h0, tag, "word in reset", aligned_word, 14'h0);
        check(aligned_valid == 1'b0, tag, "valid in reset", {13'h0, aligned_valid}, 14'h0);
    endtask

    // Driver: releases reset, streams smp[0..smp_n-1], pushes expected words.
    task automatic episode(input int nhalves, input bit drain, input string tag);
        @(negedge clk); #1;
        for (int n = 0; n < smp_n; n++) sb_q.push_back(smp[n]);
        rst = 1'b0;
        for (int r = 0; r < nhalves; r++) begin
            if (r >= 2 && (r % 2) == 0) begin
                bit exp_v = (r >= 8);
                check(aligned_valid == exp_v, (r <= 8) ? tag : "R7", "valid timing",
                      {13'h0, aligned_valid}, {13'h0, exp_v});
            end
            set_fields(r);
            @(posedge clk or negedge clk); #1;
        end
        if (drain)
            check(sb_q.size() == 0, "R4", "samples left undelivered",
                  14'(sb_q.size()), 14'h0);
        rst = 1'b1;
        @(negedge clk);
        #2;
        sb_q.delete();
        check(aligned_word == 14'h0, (drain) ? "R1" : "R8", "word after reset",
              aligned_word, 14'h0);
        check(aligned_valid == 1'b0, (drain) ? "R1" : "R8", "valid after reset",
              {13'h0, aligned_valid}, 14'h0);
    endtask

    // Monitor: scoreboard at falling edges, hold check at rising edges.
    initial begin
        logic [13:0] seen;
        logic [13:0] exp;
        forever begin
            @(negedge clk); #5;
            seen = aligned_word;
            if (aligned_valid) begin
                exp = (sb_q.size() > 0) ? sb_q.pop_front() : 14'h0;
                check(aligned_word == exp, "R4", "aligned word", aligned_word, exp);
                check(aligned_word[13:12] == exp[13:12], "R2", "stage 1 field position",
                      {12'h0, aligned_word[13:12]}, {12'h0, exp[13:12]});
                check((aligned_word & 14'h0CCC) == (exp & 14'h0CCC), "R3",
                      "falling-edge stage fields", aligned_word & 14'h0CCC, exp & 14'h0CCC);
            end
            @(posedge clk); #5;
            if (aligned_valid && !rst)
                check(aligned_word == seen, "R5", "word changed at rising edge",
                      aligned_word, seen);
        end
    end

    initial begin
        #(20 * 100000);
        n_fail++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
        $finish;
    end

    initial begin
        // R1: reset state with active input
        repeat (3) @(negedge clk);
        reset_state_check("R1");

        // Random stream, R6 timing
        smp_n = 40;
        for (int n = 0; n < smp_n; n++) smp[n] = 14'($urandom());
        episode(2 * (smp_n + 6), 1'b1, "R6");
        reset_state_check("R1");

        // Corner patterns, R2 and R3 field ordering
        smp_n = 10;
        smp[0] = 14'h3FFF; smp[1] = 14'h0000; smp[2] = 14'h2AAA; smp[3] = 14'h1555;
        smp[4] = 14'h2000; smp[5] = 14'h0001; smp[6] = 14'h0C30; smp[7] = 14'h3003;
        smp[8] = 14'h0300; smp[9] = 14'h1248;
        episode(2 * (smp_n + 6), 1'b1, "R6");

        // R8: abort mid-stream, then refill
        smp_n = 20;
        for (int n = 0; n < smp_n; n++) smp[n] = 14'($urandom());
        episode(14, 1'b0, "R6");
        reset_state_check("R8");
        smp_n = 30;
        for (int n = 0; n < smp_n; n++) smp[n] = 14'($urandom());
        episode(2 * (smp_n + 6), 1'b1, "R8");

        repeat (2) @(negedge clk);
        $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
        $finish;
    end

endmodule